// File: doc/BRIEF.md
# Self-Centering Transmit Clock-Crossing FIFO

This block carries a continuous 16-bit word stream from a write clock into a local byte clock. The write clock comes back from user logic, so it runs at the byte-clock rate but with an unknown and slowly wandering phase. One word is written on every write-clock edge and one word is read on every byte-clock edge. There is no full or empty flow control. The block instead watches how far apart the two pointers are. When they come within one entry of colliding in either direction, it raises a sticky phase-error flag and forces the read data to zero.

The user logic answers a raised flag with an init request, held high for two byte clocks, and sends filler words in the meantime. After a fixed, bounded delay the block moves its read pointer so that the pointers again sit about half the depth apart. One byte clock later it drops the flag, and from then on the words come out in their original order. The write pointer crosses into the byte-clock domain in Gray code through a two-flop synchronizer. The separation estimate adds back the known synchronizer lag.

Top module: `txc_center_fifo`

## Requirements
- R1: Once centred with the flag low, `rd_data` delivers the words presented on `wr_data` in write order, one word per `rd_clk` cycle, with no word skipped or repeated.
- R2: After reset is released, `phase_err` is 1 and `rd_data` is all zeros until the first completed initialization.
- R3: While `phase_err` is 1, `rd_data` is all zeros.
- R4: An `init_req` that is high on only one rising `rd_clk` edge is ignored, and `phase_err` stays 1.
- R5: `init_req` high on two consecutive rising `rd_clk` edges is a valid request. `phase_err` falls exactly `INIT_DLY` rising `rd_clk` edges after the second of those edges. `INIT_DLY` is limited to 2 through 8 and defaults to 4.
- R6: Centering places the lag-compensated pointer separation at about `DEPTH/2`. With both clocks at the same frequency, `phase_err` then stays 0.
- R7: When the write clock loses cycles until the separation falls to 1 or less, `phase_err` rises. It then stays 1, even after both clocks run at the same rate again, until the next initialization completes.
- R8: When the write clock gains cycles until the separation reaches `DEPTH-1` or more, `phase_err` rises.
- R9: A re-initialization after a phase error restores in-order delivery as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock returned from user logic |
| rd_clk | input | 1 | Internal byte clock that drains the FIFO |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_data | input | 16 | Word written on every rising `wr_clk` edge |
| init_req | input | 1 | Initialization request, synchronous to `rd_clk` |
| rd_data | output | 16 | Word read each `rd_clk` cycle, zero while the flag is high |
| phase_err | output | 1 | Sticky pointer-proximity error flag |

## Verification
The bench uses the default `DEPTH` of 8 and `INIT_DLY` of 4. With only eight entries, a write-clock stall of four cycles is enough to cross the low threshold, and four extra fast write pulses are enough to cross the high threshold. The bench drives both disturbances and checks that the flag is sticky and that a re-init recovers the stream. With `INIT_DLY` at 4, the exact request-to-clear latency lies inside the allowed two-to-eight window, so the bench checks it against a fixed value.

// File: rtl/txc_fifo_pkg.sv
`timescale 1ns/1ps
package txc_fifo_pkg;

  typedef enum logic [0:0] {
    IQ_IDLE = 1'b0,
    IQ_WAIT = 1'b1
  } iq_state_e;

  // Conversions on a zero-extended 16-bit field; callers truncate.
  function automatic logic [15:0] ptr_bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] ptr_gray2bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/txc_rst_sync.sv
`timescale 1ns/1ps
module txc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/txc_gray_sync.sv
`timescale 1ns/1ps
module txc_gray_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/txc_fifo_ram.sv
`timescale 1ns/1ps
module txc_fifo_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned NWORDS = 1 << AW;

  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txc_init_qual.sv
`timescale 1ns/1ps
module txc_init_qual
  import txc_fifo_pkg::*;
#(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic center
);
  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] START = CW'(DLY - 2);

  iq_state_e       state_q, state_d;
  logic            req_q;
  logic            armed_q, armed_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            valid;

  always_comb begin
    valid   = req && req_q && armed_q && (state_q == IQ_IDLE);
    state_d = state_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    center  = 1'b0;
    if (valid)     armed_d = 1'b0;
    else if (!req) armed_d = 1'b1;
    case (state_q)
      IQ_IDLE: begin
        if (valid) begin
          state_d = IQ_WAIT;
          cnt_d   = START;
        end
      end
      IQ_WAIT: begin
        if (cnt_q == '0) begin
          center  = 1'b1;
          state_d = IQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = IQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IQ_IDLE;
      req_q   <= 1'b0;
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // Independent age counter bounding the request-to-centre window.
  logic [CW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age_q <= '0;
    else if (state_q != IQ_WAIT) age_q <= '0;
    else if (age_q != '1)        age_q <= age_q + 1'b1;
  end

  p_two_cycle_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == IQ_WAIT) |-> ($past(req) && $past(req, 2)));

  p_init_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    center |-> (age_q <= CW'(6)));
endmodule

// File: rtl/txc_center_fifo.sv
`timescale 1ns/1ps
module txc_center_fifo
  import txc_fifo_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned INIT_DLY = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          arst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          init_req,
  output logic [DW-1:0] rd_data,
  output logic          phase_err
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned LAG  = 2;

  logic wr_rst_n, rd_rst_n;

  txc_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(arst_n), .srst_n(wr_rst_n));
  txc_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(arst_n), .srst_n(rd_rst_n));

  // ---------------- write domain ----------------
  logic          wr_en;
  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;

  assign wr_en = 1'b1;

  always_comb begin
    wbin_d  = wbin_q + 1'b1;
    wgray_d = PW'(ptr_bin2gray(16'(wbin_d)));
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_en) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  logic [DW-1:0] ram_rdata;
  logic [PW-1:0] rbin_q, rbin_d;

  txc_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (wr_en),
    .waddr (wbin_q[AW-1:0]),
    .wdata (wr_data),
    .raddr (rbin_q[AW-1:0]),
    .rdata (ram_rdata)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] wgray_s, wbin_s, sep_est;
  logic          near, center;
  logic          clr_q;
  logic          err_q, err_d;
  logic [DW-1:0] rd_q;

  txc_gray_sync #(.W(PW)) u_wsync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_s)
  );

  txc_init_qual #(.DLY(INIT_DLY)) u_init (
    .clk(rd_clk), .rst_n(rd_rst_n), .req(init_req), .center(center)
  );

  always_comb begin
    wbin_s  = PW'(ptr_gray2bin(16'(wgray_s)));
    sep_est = wbin_s - rbin_q + PW'(LAG);
    near    = (sep_est <= PW'(1)) || (sep_est >= PW'(DEPTH - 1));
    if (center) rbin_d = wbin_s + PW'(1 + LAG) - PW'(HALF);
    else        rbin_d = rbin_q + 1'b1;
    if (clr_q)     err_d = 1'b0;
    else if (near) err_d = 1'b1;
    else           err_d = err_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q <= '0;
      clr_q  <= 1'b0;
      err_q  <= 1'b1;
      rd_q   <= '0;
    end else begin
      rbin_q <= rbin_d;
      clr_q  <= center;
      err_q  <= err_d;
      rd_q   <= ram_rdata;
    end
  end

  assign rd_data   = err_q ? '0 : rd_q;
  assign phase_err = err_q;

  p_wgray_step_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  p_clear_after_center_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(err_q) |-> $past(center, 2));
endmodule

// File: tb/txc_center_fifo_test.sv
`timescale 1ns/1ps
module txc_center_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int INIT_DLY   = 4;

  logic        wr_clk, rd_clk, arst_n, init_req, phase_err;
  logic [15:0] wr_data, rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int wr_skip  = 0;
  int wr_fast  = 0;
  bit sb_en    = 0;
  bit aligned  = 0;
  logic [15:0] exp_q [$];

  txc_center_fifo #(.DW(16), .DEPTH(DEPTH), .INIT_DLY(INIT_DLY)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .wr_data(wr_data),
    .init_req(init_req), .rd_data(rd_data), .phase_err(phase_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    rd_clk = 0;
    forever #(CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  // Write clock and driver: each word is queued as it is presented.
  initial begin
    wr_clk  = 0;
    wr_data = 16'd0;
    exp_q.push_back(wr_data);
    #3;
    forever begin
      if (wr_skip > 0) begin
        wr_skip--;
        #(CLK_PERIOD);
      end else if (wr_fast > 0) begin
        wr_fast--;
        wr_clk = 1; #1; wr_clk = 0;
        wr_data = wr_data + 16'd1; exp_q.push_back(wr_data);
        #1;
      end else begin
        wr_clk = 1; #(CLK_PERIOD/2); wr_clk = 0;
        wr_data = wr_data + 16'd1; exp_q.push_back(wr_data);
        #(CLK_PERIOD/2);
      end
    end
  end

  // Monitor / scoreboard
  always @(negedge rd_clk) begin
    if (arst_n) begin
      if (phase_err) begin
        check(rd_data == 16'd0, "R3 masked data", rd_data, 0);
        aligned = 0;
      end else if (!sb_en) begin
        aligned = 0;
      end else if (!aligned) begin
        while (exp_q.size() > 0 && exp_q[0] != rd_data) void'(exp_q.pop_front());
        check(exp_q.size() > 0, "R1/R9 align", rd_data, -1);
        if (exp_q.size() > 0) begin
          void'(exp_q.pop_front());
          aligned = 1;
        end
      end else begin
        if (exp_q.size() == 0) check(0, "R1 order", rd_data, -1);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R1 order", rd_data, e);
        end
      end
    end
  end

  task automatic do_init(output int lat);
    lat = 0;
    @(negedge rd_clk); init_req = 1;
    @(negedge rd_clk);
    @(negedge rd_clk); init_req = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge rd_clk);
      if (lat == 0 && !phase_err) lat = i;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat;
    int bad;
    bit seen;
    arst_n = 0; init_req = 0;
    repeat (4) @(negedge rd_clk);
    arst_n = 1;
    repeat (3) @(negedge rd_clk);
    // R2 reset state
    check(phase_err == 1'b1, "R2 flag after reset", phase_err, 1);
    check(rd_data == 16'd0, "R2 data after reset", rd_data, 0);
    repeat (20) @(negedge rd_clk);
    check(phase_err == 1'b1, "R2 flag before init", phase_err, 1);

    // R4 single-cycle request ignored
    init_req = 1; @(negedge rd_clk); init_req = 0;
    bad = 0;
    repeat (12) begin @(negedge rd_clk); if (!phase_err) bad++; end
    check(bad == 0, "R4 one-cycle request", bad, 0);

    // R5 exact latency
    sb_en = 1;
    do_init(lat);
    check(lat == INIT_DLY, "R5 init latency", lat, INIT_DLY);

    // R6 stays centred
    bad = 0;
    repeat (100) begin @(negedge rd_clk); if (phase_err) bad++; end
    check(bad == 0, "R6 centred stays clear", bad, 0);

    // R7 write clock loses cycles
    sb_en = 0;
    @(negedge rd_clk); wr_skip = 4;
    seen = 0;
    repeat (20) begin @(negedge rd_clk); if (phase_err) seen = 1; end
    check(seen, "R7 flag on low separation", seen, 1);
    bad = 0;
    repeat (30) begin @(negedge rd_clk); if (!phase_err) bad++; end
    check(bad == 0, "R7 flag sticky", bad, 0);

    // R9 recovery
    sb_en = 1;
    do_init(lat);
    check(lat == INIT_DLY, "R9 re-init latency", lat, INIT_DLY);
    bad = 0;
    repeat (60) begin @(negedge rd_clk); if (phase_err) bad++; end
    check(bad == 0, "R9 clear after re-init", bad, 0);

    // R8 write clock gains cycles
    sb_en = 0;
    @(negedge rd_clk); wr_fast = 4;
    seen = 0;
    repeat (20) begin @(negedge rd_clk); if (phase_err) seen = 1; end
    check(seen, "R8 flag on high separation", seen, 1);
    sb_en = 1;
    do_init(lat);
    check(lat == INIT_DLY, "R9 re-init after gain", lat, INIT_DLY);
    bad = 0;
    repeat (60) begin @(negedge rd_clk); if (phase_err) bad++; end
    check(bad == 0, "R9 clear after gain", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule